// File: doc/BRIEF.md
# 16-bit address arithmetic unit

This unit performs the 16-bit add operations of an 8-bit accumulator CPU: adding a register pair to the HL pair, and adding a signed 8-bit displacement to the stack pointer. The sum can go back to the stack pointer or into HL. The arithmetic is combinational. The result, the updated flag nibble and a destination indication are captured in one register stage. They appear together with a one-cycle valid pulse on the clock after the input strobe.

The two operations use different flag rules. The register-pair add takes its half-carry from bit 11 and its carry from bit 15, clears N, and leaves Z as it was. The displacement add produces a 16-bit sign-extended sum. Its H and C flags, however, come from an unsigned 8-bit add of the low byte of the base and the raw displacement byte, and Z and N are always cleared. Register storage and instruction decode belong to the surrounding core.

Top module: `addr_alu`

## Requirements
- R1: With op_i = 0 or 3 (pair add), result_o is (x_i + y_i) mod 2^16.
- R2: In the pair add, flag H (flags_o[1]) is set exactly when x_i[11:0] + y_i[11:0] exceeds 0xFFF, and flag C (flags_o[0]) is set exactly when x_i + y_i exceeds 0xFFFF.
- R3: In the pair add, flag N (flags_o[2]) is 0 and flag Z (flags_o[3]) equals flags_i[3].
- R4: With op_i = 1 or 2 (displacement add), result_o is x_i plus y_i[7:0] sign-extended to 16 bits, mod 2^16; y_i[15:8] has no effect.
- R5: In the displacement add, H is set exactly when x_i[3:0] + y_i[3:0] exceeds 0xF, and C is set exactly when x_i[7:0] + y_i[7:0] exceeds 0xFF, both as unsigned adds.
- R6: In the displacement add, Z and N are both 0 for either destination.
- R7: dst_hl_o is 1 for op_i 0, 2 and 3 and 0 for op_i 1 (result to the stack pointer).
- R8: out_valid_o is high on exactly the cycle after each cycle with in_valid_i high, and result_o, flags_o and dst_hl_o are updated on that same edge.
- R9: On a cycle with in_valid_i low, result_o, flags_o and dst_hl_o keep their values.
- R10: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 0/3 pair add, 1 displacement to SP, 2 displacement to HL |
| x_i | input | 16 | Base operand (HL or SP) |
| y_i | input | 16 | Pair operand, or displacement in bits 7:0 |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| result_o | output | 16 | Registered sum |
| flags_o | output | 4 | Registered flags {Z,N,H,C} |
| dst_hl_o | output | 1 | 1 when the result targets HL |
| out_valid_o | output | 1 | Result valid pulse |

## Verification
A wrong carry path shows up as a bad H or C bit on the cycle right after the strobe. A flag taken from the wrong bit of the adder matters mostly at boundaries such as 0x0FFF+1, 0xFFFF+1 and a base low byte of 0xF8 with displacement 0x08. An incorrect sign extension gives a wrong upper byte only for displacements of 0x80 and above. A stage that fails to hold is visible on the first idle cycle after an operation, when the outputs change without a strobe.

// File: rtl/addr_alu_pkg.sv
package addr_alu_pkg;
  typedef enum logic [1:0] {
    OP_PAIR     = 2'd0,
    OP_SP_DISP  = 2'd1,
    OP_HL_DISP  = 2'd2,
    OP_PAIR_ALT = 2'd3
  } op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;
endpackage

// File: rtl/pair_adder.sv
module pair_adder
  import addr_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  flags_t       flags_i,
  output logic [W-1:0] sum_o,
  output flags_t       flags_o
);
  localparam int HW = W - 4;

  logic [W:0]  full_sum;
  logic [HW:0] low_sum;

  assign full_sum = {1'b0, a_i} + {1'b0, b_i};
  assign low_sum  = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]};
  assign sum_o    = full_sum[W-1:0];

  always_comb begin
    flags_o.z = flags_i.z;  // zero flag untouched by 16-bit pair add
    flags_o.n = 1'b0;
    flags_o.h = low_sum[HW];
    flags_o.c = full_sum[W];
  end
endmodule

// File: rtl/disp_adder.sv
module disp_adder
  import addr_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic [W-1:0]  a_i,
  input  logic [DW-1:0] d_i,
  output logic [W-1:0]  sum_o,
  output flags_t        flags_o
);
  localparam int EXT = W - DW;

  logic [W-1:0] d_ext;
  logic [DW:0]  byte_sum;
  logic [4:0]   nib_sum;

  assign d_ext    = {{EXT{d_i[DW-1]}}, d_i};
  assign sum_o    = a_i + d_ext;
  // flags from an unsigned add of the low byte, independent of sign
  assign byte_sum = {1'b0, a_i[DW-1:0]} + {1'b0, d_i};
  assign nib_sum  = {1'b0, a_i[3:0]} + {1'b0, d_i[3:0]};

  always_comb begin
    flags_o.z = 1'b0;
    flags_o.n = 1'b0;
    flags_o.h = nib_sum[4];
    flags_o.c = byte_sum[DW];
  end
endmodule

// File: rtl/out_stage.sv
module out_stage
  import addr_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] res_i,
  input  flags_t       flags_i,
  input  logic         dst_hl_i,
  output logic [W-1:0] res_o,
  output flags_t       flags_o,
  output logic         dst_hl_o,
  output logic         valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o    <= '0;
      flags_o  <= '0;
      dst_hl_o <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        res_o    <= res_i;
        flags_o  <= flags_i;
        dst_hl_o <= dst_hl_i;
      end
    end
  end
endmodule

// File: rtl/addr_alu.sv
module addr_alu
  import addr_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DISP_W = 8,
  parameter int FLAG_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              dst_hl_o,
  output logic              out_valid_o
);
  op_e               op;
  flags_t            cur_flags;
  logic [DATA_W-1:0] pair_sum, disp_sum, sel_sum;
  flags_t            pair_flags, disp_flags, sel_flags, q_flags;
  logic              is_disp, sel_dst_hl;

  assign op        = op_e'(op_i);
  assign cur_flags = flags_t'(flags_i);

  pair_adder #(.W(DATA_W)) u_pair (
    .a_i    (x_i),
    .b_i    (y_i),
    .flags_i(cur_flags),
    .sum_o  (pair_sum),
    .flags_o(pair_flags)
  );

  disp_adder #(.W(DATA_W), .DW(DISP_W)) u_disp (
    .a_i    (x_i),
    .d_i    (y_i[DISP_W-1:0]),
    .sum_o  (disp_sum),
    .flags_o(disp_flags)
  );

  always_comb begin
    is_disp    = (op == OP_SP_DISP) || (op == OP_HL_DISP);
    sel_dst_hl = (op != OP_SP_DISP);
    sel_sum    = is_disp ? disp_sum : pair_sum;
    sel_flags  = is_disp ? disp_flags : pair_flags;
  end

  out_stage #(.W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (in_valid_i),
    .res_i   (sel_sum),
    .flags_i (sel_flags),
    .dst_hl_i(sel_dst_hl),
    .res_o   (result_o),
    .flags_o (q_flags),
    .dst_hl_o(dst_hl_o),
    .valid_o (out_valid_o)
  );

  assign flags_o = q_flags;
endmodule

// File: rtl/addr_alu_chk.sv
module addr_alu_chk #(
  parameter int DATA_W = 16,
  parameter int DISP_W = 8,
  parameter int FLAG_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] x_i,
  input logic [DATA_W-1:0] y_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              dst_hl_o,
  input logic              out_valid_o
);
  logic pair_op, disp_op;
  logic [DATA_W:0] wide_sum;

  assign pair_op  = in_valid_i && (op_i == 2'd0 || op_i == 2'd3);
  assign disp_op  = in_valid_i && (op_i == 2'd1 || op_i == 2'd2);
  assign wide_sum = {1'b0, x_i} + {1'b0, y_i};

  a_r1_pair_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_op |=> result_o == $past(wide_sum[DATA_W-1:0]));
  a_r2_pair_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_op |=> flags_o[0] == $past(wide_sum[DATA_W]));
  a_r3_z_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_op |=> (flags_o[3] == $past(flags_i[3])) && !flags_o[2]);
  a_r6_zn_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_op |=> flags_o[3:2] == 2'b00);
  a_r7_dst_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 2'd1) |=> !dst_hl_o);
  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(result_o) && $stable(flags_o) && $stable(dst_hl_o)));

  always_comb begin
    if (!rst_ni) begin
      a_r10_reset_clear: assert (out_valid_o == 1'b0 && result_o == '0 && flags_o == '0);
    end
  end
endmodule

bind addr_alu addr_alu_chk #(
  .DATA_W(DATA_W),
  .DISP_W(DISP_W),
  .FLAG_W(FLAG_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .op_i       (op_i),
  .x_i        (x_i),
  .y_i        (y_i),
  .flags_i    (flags_i),
  .result_o   (result_o),
  .flags_o    (flags_o),
  .dst_hl_o   (dst_hl_o),
  .out_valid_o(out_valid_o)
);

// File: tb/addr_alu_tb.sv
`timescale 1ns/1ps
module addr_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [15:0] x = '0, y = '0;
  logic [3:0]  fl = '0;
  logic [15:0] result;
  logic [3:0]  flags;
  logic        dst_hl, out_valid;

  int checks = 0, errors = 0;
  int exp_res = 0, exp_fl = 0, exp_dst = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_i(op),
    .x_i(x), .y_i(y), .flags_i(fl), .result_o(result), .flags_o(flags),
    .dst_hl_o(dst_hl), .out_valid_o(out_valid)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference for one operation
  task automatic step(bit v, int o, int xv, int yv, int fv);
    int s, d, sd, h, c, z;
    bit disp;
    @(negedge clk);
    in_valid = v; op = 2'(o); x = 16'(xv); y = 16'(yv); fl = 4'(fv);
    disp = (o == 1 || o == 2);
    if (v) begin
      if (!disp) begin
        s = xv + yv;
        exp_res = s % 65536;
        h = (((xv % 4096) + (yv % 4096)) >= 4096) ? 1 : 0;
        c = (s >= 65536) ? 1 : 0;
        z = (fv >> 3) & 1;
        exp_fl = z * 8 + h * 2 + c;
      end else begin
        d = yv % 256;
        sd = (d >= 128) ? d - 256 : d;
        exp_res = (xv + sd + 65536) % 65536;
        h = (((xv % 16) + (d % 16)) > 15) ? 1 : 0;
        c = (((xv % 256) + d) > 255) ? 1 : 0;
        exp_fl = h * 2 + c;
      end
      exp_dst = (o == 1) ? 0 : 1;
    end
    @(posedge clk);
    #1;
    check("R8 out_valid", out_valid, v);
    if (v && !disp) begin
      check("R1 pair result", result, exp_res);
      check("R2 pair H/C", flags & 3, exp_fl & 3);
      check("R3 pair Z/N", flags >> 2, exp_fl >> 2);
    end else if (v) begin
      check("R4 disp result", result, exp_res);
      check("R5 disp H/C", flags & 3, exp_fl & 3);
      check("R6 disp Z/N", flags >> 2, 0);
    end else begin
      check("R9 hold result", result, exp_res);
      check("R9 hold flags", flags, exp_fl);
    end
    if (v) check("R7 destination", dst_hl, exp_dst);
    else   check("R9 hold dst", dst_hl, exp_dst);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset result", result, 0);
    check("R10 reset flags", flags, 0);
    check("R10 reset valid", out_valid, 0);
    @(negedge clk) rst_n = 1'b1;

    // pair add corners
    step(1, 0, 16'h0FFF, 16'h0001, 4'h0);   // H only
    step(1, 0, 16'hFFFF, 16'h0001, 4'h0);   // H, C, zero result, Z kept 0
    step(1, 3, 16'h8000, 16'h8000, 4'h8);   // C only, Z kept 1
    step(1, 0, 16'h1234, 16'h0F00, 4'hF);   // N cleared, Z kept
    step(0, 0, 16'h0000, 16'h0000, 4'h0);   // idle hold
    // displacement corners
    step(1, 1, 16'hFFF8, 16'h0008, 4'hF);   // wraps to 0, H and C, Z cleared
    step(1, 2, 16'h0000, 16'h00FF, 4'hF);   // -1, no flags
    step(1, 1, 16'h1000, 16'hAB80, 4'h0);   // -128, upper y ignored
    step(1, 2, 16'h00FF, 16'h0001, 4'h8);   // H and C from low byte
    step(1, 1, 16'h0100, 16'h007F, 4'h0);
    step(0, 2, 16'h5555, 16'h5555, 4'hF);   // idle hold
    step(0, 1, 16'h0001, 16'h0002, 4'h0);

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, $urandom % 4, $urandom % 65536,
           $urandom % 65536, $urandom % 16);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule